// File: doc/BRIEF.md
# Receive Packet Filter Table

This block keeps a small table of registered receivers and decides, for every incoming UDP packet, whether its payload is delivered or thrown away. A receiver is registered by a four-word configure command on a 32-bit word stream. The block parses the command and stores the receiver in the lowest free table slot. It then returns an acknowledge word, or a negative acknowledge when every slot is taken.

Each packet header carries a byte length, a source IPv4 address, source and destination ports and an error flag. The header is compared against all valid entries in parallel. If an entry matches and the error flag is clear, the decision is "keep" and the entry's bus address is reported. In every other case the decision is "drop". The block then consumes the packet's 16-bit payload items one by one and flags each item of a dropped packet. It does not take the next header until the last item of the current packet has been consumed.

The configure parser has the states C_IDLE, C_IP, C_PORTS, C_ADDR and C_COMMIT. It moves C_IDLE→C_IP on an opcode word, advances C_IP→C_PORTS→C_ADDR→C_COMMIT with each accepted word, and always goes C_COMMIT→C_IDLE. The packet sequencer has the states P_IDLE, P_LOOKUP and P_DRAIN. It moves P_IDLE→P_LOOKUP on a header. From P_LOOKUP it goes to P_DRAIN, or straight back to P_IDLE for a zero-length packet. It returns P_DRAIN→P_IDLE when the last item is consumed.

Top module: `rx_filter_table`

## Requirements
- R1: After reset the table is empty, `hdr_ready` and `cfg_ready` are 1, and `dec_valid`, `ack_valid` and `item_ready` are 0.
- R2: A configure command starts with a word whose bits 31:28 equal 3. It is followed by three words: the source IP, then {destination port in bits 31:16, source port in bits 15:0}, then the bus address. Words that arrive while waiting for a command start and do not carry opcode 3 are ignored.
- R3: A successful configure stores the entry in the lowest free slot. One cycle after the fourth word is accepted, `ack_valid` pulses with `ack_word` = 0x50 in bits 31:24, zeros below, and the slot index in the low bits. `cfg_ready` is 0 during the cycle between.
- R4: A configure while all slots are valid returns `ack_word` = 0x51000000 and leaves the table unchanged, so a packet with that rejected key is dropped.
- R5: A packet matches an entry only if source IP, source port and destination port are all equal to the entry's values.
- R6: When several entries match, the entry with the lowest index supplies `dec_addr`.
- R7: A packet with `hdr_err` set is dropped even when it matches an entry.
- R8: `dec_valid` pulses for one cycle after the second clock edge following header acceptance. `dec_keep` and `dec_addr` are valid with it; `dec_addr` is 0 on a drop.
- R9: A packet of L bytes has ceil(L/2) payload items, so a 1-byte packet has one item. `item_ready` is 1 only while items remain. `item_drop` is 1 for each consumed item of a dropped packet and 0 for a kept one.
- R10: `hdr_ready` is 0 from header acceptance until the last item is consumed, and is 1 again in the next cycle. For a zero-length packet it is 1 again together with `dec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configure word present |
| cfg_word | input | 32 | Configure word |
| cfg_ready | output | 1 | Configure word is accepted this cycle |
| ack_valid | output | 1 | Acknowledge word valid (one-cycle pulse) |
| ack_word | output | 32 | Acknowledge or negative acknowledge word |
| hdr_valid | input | 1 | New packet header strobe |
| hdr_ready | output | 1 | Header can be accepted |
| hdr_len | input | LEN_W | Packet length in bytes |
| hdr_src_ip | input | 32 | Packet source IPv4 address |
| hdr_src_port | input | 16 | Packet source port |
| hdr_dst_port | input | 16 | Packet destination port |
| hdr_err | input | 1 | Packet marked erroneous |
| item_valid | input | 1 | One 16-bit payload item is offered |
| item_ready | output | 1 | Block consumes payload items |
| item_drop | output | 1 | Current item belongs to a dropped packet |
| dec_valid | output | 1 | Decision pulse |
| dec_keep | output | 1 | 1 = deliver packet, 0 = discard |
| dec_addr | output | ADDR_W | Bus address of the matching receiver |

## Verification
The filter is tried with packets that match exactly, with an unknown source IP, and with keys that differ in one port only. Together these show whether all three fields take part in the compare. A key registered twice shows whether the lowest slot has priority. An error-flagged packet with a matching key shows that the error flag overrides a hit. A key whose configure was refused shows that a refused configure leaves the table unchanged. Lengths of 0, 1, odd and even bytes tell apart correct and off-by-one item counting, and correct or late return of `hdr_ready`.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int WORD_W = 32;
    localparam int IP_W   = 32;
    localparam int PORT_W = 16;
    localparam logic [3:0] OP_RXCFG = 4'd3;
    localparam logic [7:0] ACK_OK   = 8'h50;
    localparam logic [7:0] ACK_FULL = 8'h51;

    typedef struct packed {
        logic [IP_W-1:0]   ip;
        logic [PORT_W-1:0] sport;
        logic [PORT_W-1:0] dport;
    } rxf_key_t;

    typedef enum logic [2:0] {C_IDLE, C_IP, C_PORTS, C_ADDR, C_COMMIT} cfg_state_t;
    typedef enum logic [1:0] {P_IDLE, P_LOOKUP, P_DRAIN} pkt_state_t;
endpackage

// File: rtl/rxf_table.sv
module rxf_table
    import rxf_pkg::*;
#(
    parameter int N      = 4,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  rxf_key_t          wr_key,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              full,
    output logic [IDX_W-1:0]  free_idx,
    input  rxf_key_t          lk_key,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_addr,
    output logic [N-1:0]      valid
);
    rxf_key_t          keys  [N];
    logic [ADDR_W-1:0] addrs [N];
    logic [N-1:0]      hits;

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[g] <= 1'b0;
                keys[g]  <= '0;
                addrs[g] <= '0;
            end else if (wr_en && free_idx == IDX_W'(g)) begin
                valid[g] <= 1'b1;
                keys[g]  <= wr_key;
                addrs[g] <= wr_addr;
            end
        end
        assign hits[g] = valid[g] && (keys[g] == lk_key);
    end

    always_comb begin
        full     = &valid;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    always_comb begin
        lk_hit  = |hits;
        lk_addr = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) lk_addr = addrs[i];
        end
    end
endmodule

// File: rtl/rxf_cfg_fsm.sv
module rxf_cfg_fsm
    import rxf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [WORD_W-1:0] cfg_word,
    output logic              cfg_ready,
    output logic              ack_valid,
    output logic [WORD_W-1:0] ack_word,
    input  logic              tbl_full,
    input  logic [IDX_W-1:0]  tbl_free_idx,
    output logic              wr_en,
    output rxf_key_t          wr_key,
    output logic [ADDR_W-1:0] wr_addr
);
    cfg_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= C_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            C_IDLE:   if (cfg_valid && cfg_word[31:28] == OP_RXCFG) nxt = C_IP;
            C_IP:     if (cfg_valid) nxt = C_PORTS;
            C_PORTS:  if (cfg_valid) nxt = C_ADDR;
            C_ADDR:   if (cfg_valid) nxt = C_COMMIT;
            C_COMMIT: nxt = C_IDLE;
            default:  nxt = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_key    <= '0;
            wr_addr   <= '0;
            ack_valid <= 1'b0;
            ack_word  <= '0;
        end else begin
            if (state == C_IP && cfg_valid)    wr_key.ip <= cfg_word;
            if (state == C_PORTS && cfg_valid) begin
                wr_key.dport <= cfg_word[31:16];
                wr_key.sport <= cfg_word[15:0];
            end
            if (state == C_ADDR && cfg_valid)  wr_addr <= ADDR_W'(cfg_word);
            ack_valid <= (state == C_COMMIT);
            if (state == C_COMMIT) begin
                if (tbl_full) ack_word <= {ACK_FULL, 24'd0};
                else          ack_word <= {ACK_OK, (24-IDX_W)'(0), tbl_free_idx};
            end
        end
    end

    always_comb begin
        cfg_ready = (state != C_COMMIT);
        wr_en     = (state == C_COMMIT) && !tbl_full;
    end
endmodule

// File: rtl/rxf_pkt_fsm.sv
module rxf_pkt_fsm
    import rxf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic [LEN_W-1:0]  hdr_len,
    input  rxf_key_t          hdr_key,
    input  logic              hdr_err,
    input  logic              item_valid,
    output logic              item_ready,
    output logic              item_drop,
    output rxf_key_t          lk_key,
    input  logic              lk_hit,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              dec_valid,
    output logic              dec_keep,
    output logic [ADDR_W-1:0] dec_addr
);
    pkt_state_t        state, nxt;
    logic [LEN_W-1:0]  len_q, left_q;
    logic              err_q;
    logic [LEN_W:0]    items_w;

    assign items_w = ({1'b0, len_q} + (LEN_W+1)'(1)) >> 1;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= P_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            P_IDLE:   if (hdr_valid) nxt = P_LOOKUP;
            P_LOOKUP: nxt = (items_w == '0) ? P_IDLE : P_DRAIN;
            P_DRAIN:  if (item_valid && left_q == LEN_W'(1)) nxt = P_IDLE;
            default:  nxt = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_key    <= '0;
            len_q     <= '0;
            err_q     <= 1'b0;
            left_q    <= '0;
            dec_valid <= 1'b0;
            dec_keep  <= 1'b0;
            dec_addr  <= '0;
        end else begin
            if (state == P_IDLE && hdr_valid) begin
                lk_key <= hdr_key;
                len_q  <= hdr_len;
                err_q  <= hdr_err;
            end
            dec_valid <= (state == P_LOOKUP);
            if (state == P_LOOKUP) begin
                dec_keep <= lk_hit && !err_q;
                dec_addr <= (lk_hit && !err_q) ? lk_addr : '0;
                left_q   <= items_w[LEN_W-1:0];
            end else if (state == P_DRAIN && item_valid) begin
                left_q <= left_q - LEN_W'(1);
            end
        end
    end

    always_comb begin
        hdr_ready  = (state == P_IDLE);
        item_ready = (state == P_DRAIN);
        item_drop  = (state == P_DRAIN) && item_valid && !dec_keep;
    end

    // R9: a drop flag only accompanies an item that is really consumed
    p_drop_needs_item_r9: assert property (@(posedge clk) disable iff (!rst_n)
        item_drop |-> (item_valid && item_ready));
endmodule

// File: rtl/rx_filter_table.sv
module rx_filter_table
    import rxf_pkg::*;
#(
    parameter int N_ENTRIES = 4,
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [31:0]       cfg_word,
    output logic              cfg_ready,
    output logic              ack_valid,
    output logic [31:0]       ack_word,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic [31:0]       hdr_src_ip,
    input  logic [15:0]       hdr_src_port,
    input  logic [15:0]       hdr_dst_port,
    input  logic              hdr_err,
    input  logic              item_valid,
    output logic              item_ready,
    output logic              item_drop,
    output logic              dec_valid,
    output logic              dec_keep,
    output logic [ADDR_W-1:0] dec_addr
);
    rxf_key_t              wr_key, lk_key, hdr_key;
    logic                  wr_en, tbl_full, lk_hit;
    logic [IDX_W-1:0]      free_idx;
    logic [ADDR_W-1:0]     wr_addr, lk_addr;
    logic [N_ENTRIES-1:0]  tbl_valid;

    assign hdr_key = '{ip: hdr_src_ip, sport: hdr_src_port, dport: hdr_dst_port};

    rxf_table #(.N(N_ENTRIES), .ADDR_W(ADDR_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_key(wr_key), .wr_addr(wr_addr),
        .full(tbl_full), .free_idx(free_idx),
        .lk_key(lk_key), .lk_hit(lk_hit), .lk_addr(lk_addr),
        .valid(tbl_valid)
    );

    rxf_cfg_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_word(cfg_word), .cfg_ready(cfg_ready),
        .ack_valid(ack_valid), .ack_word(ack_word),
        .tbl_full(tbl_full), .tbl_free_idx(free_idx),
        .wr_en(wr_en), .wr_key(wr_key), .wr_addr(wr_addr)
    );

    rxf_pkt_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_pkt (
        .clk(clk), .rst_n(rst_n),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_len(hdr_len),
        .hdr_key(hdr_key), .hdr_err(hdr_err),
        .item_valid(item_valid), .item_ready(item_ready), .item_drop(item_drop),
        .lk_key(lk_key), .lk_hit(lk_hit), .lk_addr(lk_addr),
        .dec_valid(dec_valid), .dec_keep(dec_keep), .dec_addr(dec_addr)
    );

    // R3: a positive acknowledge names a slot that is now occupied
    p_ack_slot_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_word[31:24] == ACK_OK) |-> tbl_valid[ack_word[IDX_W-1:0]]);

    // R4: a negative acknowledge only when full, and the table did not change
    p_nack_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_word[31:24] == ACK_FULL) |-> ((&tbl_valid) && $stable(tbl_valid)));

    // R7: an error-flagged header always ends in a drop decision
    p_err_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready && hdr_err) |=> ##1 (dec_valid && !dec_keep));

    // R10: no second header is taken right after one is accepted
    p_hdr_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |=> !hdr_ready);
endmodule

// File: tb/rx_filter_table_tb.sv
module rx_filter_table_tb_top;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_valid = 1'b0;
    logic [31:0] cfg_word = '0;
    logic cfg_ready, ack_valid;
    logic [31:0] ack_word;
    logic hdr_valid = 1'b0;
    logic hdr_ready;
    logic [LEN_W-1:0] hdr_len = '0;
    logic [31:0] hdr_src_ip = '0;
    logic [15:0] hdr_src_port = '0, hdr_dst_port = '0;
    logic hdr_err = 1'b0;
    logic item_valid = 1'b0;
    logic item_ready, item_drop, dec_valid, dec_keep;
    logic [ADDR_W-1:0] dec_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    rx_filter_table #(.N_ENTRIES(4), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_word(cfg_word), .cfg_ready(cfg_ready),
        .ack_valid(ack_valid), .ack_word(ack_word),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_len(hdr_len),
        .hdr_src_ip(hdr_src_ip), .hdr_src_port(hdr_src_port),
        .hdr_dst_port(hdr_dst_port), .hdr_err(hdr_err),
        .item_valid(item_valid), .item_ready(item_ready), .item_drop(item_drop),
        .dec_valid(dec_valid), .dec_keep(dec_keep), .dec_addr(dec_addr)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1", "hdr_ready", hdr_ready, 1);
        check("R1", "cfg_ready", cfg_ready, 1);
        check("R1", "dec_valid", dec_valid, 0);
        check("R1", "ack_valid", ack_valid, 0);
        check("R1", "item_ready", item_ready, 0);
    endtask

    task automatic send_word(logic [31:0] w);
        cfg_valid = 1'b1;
        cfg_word  = w;
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    // R2 R3 R4: one configure command and its acknowledge
    task automatic do_cfg(string req, logic [31:0] ip, logic [15:0] sp, logic [15:0] dp,
                          logic [31:0] addr, logic [31:0] exp_ack);
        send_word(32'h3000_0000);
        send_word(ip);
        send_word({dp, sp});
        send_word(addr);
        check(req, "ack early", ack_valid, 0);
        check("R3", "cfg_ready in commit", cfg_ready, 0);
        @(negedge clk);
        check(req, "ack_valid", ack_valid, 1);
        check(req, "ack_word", ack_word, exp_ack);
        @(negedge clk);
        check(req, "ack pulse end", ack_valid, 0);
    endtask

    // R5..R10: header, decision and payload drain
    task automatic do_pkt(string req, logic [31:0] ip, logic [15:0] sp, logic [15:0] dp,
                          int len, logic err, logic keep, logic [31:0] addr);
        int items;
        items = (len + 1) / 2;
        check("R10", "hdr_ready idle", hdr_ready, 1);
        hdr_valid = 1'b1; hdr_len = LEN_W'(len); hdr_src_ip = ip;
        hdr_src_port = sp; hdr_dst_port = dp; hdr_err = err;
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
        check("R10", "hdr_ready busy", hdr_ready, 0);
        check("R8", "dec_valid early", dec_valid, 0);
        @(negedge clk);
        check("R8", "dec_valid", dec_valid, 1);
        check(req, "dec_keep", dec_keep, keep);
        check(req, "dec_addr", dec_addr, keep ? addr : 32'd0);
        if (items == 0) begin
            check("R10", "hdr_ready zero len", hdr_ready, 1);
        end else begin
            for (int k = 0; k < items; k++) begin
                item_valid = 1'b1;
                #1;
                check("R9", "item_ready", item_ready, 1);
                check("R9", "item_drop", item_drop, !keep);
                @(posedge clk);
                @(negedge clk);
                item_valid = 1'b0;
            end
            check("R9", "item_ready after last", item_ready, 0);
            check("R10", "hdr_ready after last", hdr_ready, 1);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        // R2: a stray non-command word is ignored, so the first ack names slot 0
        send_word(32'h1000_1234);
        do_cfg("R2", 32'h1234_5678, 16'h2323, 16'h3232, 32'h0080_abba, 32'h5000_0000);
        do_cfg("R3", 32'h2345_6789, 16'h3434, 16'h4343, 32'h0080_beba, 32'h5000_0001);
        do_cfg("R6", 32'h1234_5678, 16'h2323, 16'h3232, 32'h0090_0000, 32'h5000_0002);
        do_cfg("R3", 32'h3456_789a, 16'h0001, 16'h0002, 32'h00a0_0000, 32'h5000_0003);
        do_cfg("R4", 32'h4567_89ab, 16'h0005, 16'h0006, 32'h00b0_0000, 32'h5100_0000);

        do_pkt("R6", 32'h1234_5678, 16'h2323, 16'h3232, 100, 1'b0, 1'b1, 32'h0080_abba);
        do_pkt("R5", 32'h00ff_0000, 16'h2323, 16'h3232, 20, 1'b0, 1'b0, 32'h0);
        do_pkt("R7", 32'h2345_6789, 16'h3434, 16'h4343, 30, 1'b1, 1'b0, 32'h0);
        do_pkt("R9", 32'h2345_6789, 16'h3434, 16'h4343, 1, 1'b0, 1'b1, 32'h0080_beba);
        do_pkt("R5", 32'h1234_5678, 16'h2323, 16'h2323, 4, 1'b0, 1'b0, 32'h0);
        do_pkt("R5", 32'h1234_5678, 16'h3232, 16'h3232, 4, 1'b0, 1'b0, 32'h0);
        do_pkt("R4", 32'h4567_89ab, 16'h0005, 16'h0006, 7, 1'b0, 1'b0, 32'h0);
        do_pkt("R10", 32'h3456_789a, 16'h0001, 16'h0002, 0, 1'b0, 1'b1, 32'h00a0_0000);
        do_pkt("R9", 32'h3456_789a, 16'h0001, 16'h0002, 13, 1'b0, 1'b1, 32'h00a0_0000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule